// File: doc/BRIEF.md
# Interrupt Enable and Halt Controller

This block holds the interrupt-enable state, the interrupt mode and the halted state of a small 8-bit processor core. The instruction decoder feeds it one-cycle strobes for the control instructions (no-operation, halt, disable interrupts, enable interrupts, set interrupt mode). Alongside these comes an end-of-instruction strobe that marks each instruction boundary. A control strobe only counts in a cycle where the end strobe is also high.

At each boundary the block decides whether a pending maskable request is taken. A request is not taken at the boundary of an enable instruction, so the instruction that follows always runs before any interrupt. After a halt instruction the block raises a dummy-fetch request. The fetch unit then keeps re-reading the next opcode so that memory refresh continues. Each of those dummy fetches still ends with a boundary strobe, and the halted state lasts until a request is taken or reset is applied. For every boundary the block also reports the machine-cycle and clock-state cost of the control instruction that just completed.

Top module: `intctl_top`

## Requirements
- R1: While rst_n is low and after its release, before any boundary, both enable outputs are 0, int_mode is 0, halted, dummy_fetch and irq_ack are 0, and cost_t and cost_m are 0.
- R2: A disable strobe at a boundary makes iff1 and iff2 read 0 from the next cycle. A request present at that same boundary is not taken.
- R3: An enable strobe at a boundary makes iff1 and iff2 read 1 from the next cycle.
- R4: irq_ack is high in the boundary cycle itself exactly when irq_req is high, iff1 is 1, and the completing instruction is neither enable nor disable. At the boundary of an enable instruction, including a chain of back-to-back enables, no request is taken. At the boundary of the instruction that follows, it is.
- R5: A taken request makes iff1 and iff2 read 0 from the next cycle.
- R6: A halt strobe at a boundary where no request is taken makes halted read 1 from the next cycle. dummy_fetch always equals halted.
- R7: halted stays 1 across any number of dummy-fetch boundaries until a request is taken, and then reads 0 from the next cycle. A request taken at the halt's own boundary leaves halted at 0.
- R8: A mode strobe with im_sel 0, 1 or 2 sets int_mode to im_sel from the next cycle. im_sel 3 leaves int_mode unchanged.
- R9: From the cycle after a boundary, cost_t/cost_m read 4/1 for no-operation, halt, disable and enable, 8/2 for set-mode, and 0/0 for any other instruction. They hold between boundaries.
- R10: Control strobes in a cycle without ins_end change no output.
- R11: A no-operation boundary leaves iff1, iff2, int_mode and halted unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ins_end | input | 1 | Instruction boundary strobe |
| op_nop | input | 1 | No-operation completes |
| op_halt | input | 1 | Halt completes |
| op_di | input | 1 | Disable-interrupts completes |
| op_ei | input | 1 | Enable-interrupts completes |
| op_im | input | 1 | Set-mode completes |
| im_sel | input | 2 | Mode operand for set-mode |
| irq_req | input | 1 | Maskable interrupt request, active high |
| iff1 | output | 1 | Primary interrupt enable |
| iff2 | output | 1 | Saved copy of the enable |
| int_mode | output | 2 | Current interrupt mode |
| halted | output | 1 | Processor is halted |
| dummy_fetch | output | 1 | Request a dummy opcode fetch from the next address |
| irq_ack | output | 1 | Request taken at this boundary |
| cost_t | output | 4 | Clock states of the last control instruction |
| cost_m | output | 2 | Machine cycles of the last control instruction |

## Verification
irq_ack is combinational on the boundary cycle. The bench checks it one nanosecond after driving the inputs, before the rising edge, using the model's state from before that edge. All other outputs are registered and change at the rising edge that ends the boundary cycle. They are checked at the following falling edge, after the model has applied the same update. Because each stimulus is driven on a falling edge and every result is read at the next falling edge, a wrong latency of even one cycle shows up as a mismatch.

// File: rtl/intctl_pkg.sv
package intctl_pkg;

  typedef enum logic [1:0] {
    IMODE0 = 2'd0,
    IMODE1 = 2'd1,
    IMODE2 = 2'd2
  } imode_e;

  // control-instruction strobes, already qualified by the boundary
  typedef struct packed {
    logic nop;
    logic halt;
    logic di;
    logic ei;
    logic im;
  } ctl_op_t;

endpackage

// File: rtl/intctl_enable.sv
module intctl_enable #(
  parameter int EI_HOLD = 1  // boundaries blocked after enable, own one included
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ins_end,
  input  logic di,
  input  logic ei,
  input  logic irq_req,
  output logic iff1,
  output logic iff2,
  output logic irq_ack
);

  localparam int CW = (EI_HOLD > 1) ? $clog2(EI_HOLD) : 1;

  logic iff1_q, iff1_d, iff2_q, iff2_d;
  logic hold_nz;

  generate
    if (EI_HOLD > 1) begin : g_hold
      logic [CW-1:0] cnt_q, cnt_d;
      always_comb begin
        cnt_d = cnt_q;
        if (ins_end) begin
          if (ei)
            cnt_d = CW'(EI_HOLD - 1);
          else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
        end
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end
      assign hold_nz = (cnt_q != '0);
    end else begin : g_nohold
      assign hold_nz = 1'b0;
    end
  endgenerate

  assign irq_ack = ins_end & irq_req & iff1_q & ~ei & ~di & ~hold_nz;

  always_comb begin
    iff1_d = iff1_q;
    iff2_d = iff2_q;
    if (irq_ack) begin
      iff1_d = 1'b0;
      iff2_d = 1'b0;
    end else if (di) begin
      iff1_d = 1'b0;
      iff2_d = 1'b0;
    end else if (ei) begin
      iff1_d = 1'b1;
      iff2_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iff1_q <= 1'b0;
      iff2_q <= 1'b0;
    end else begin
      iff1_q <= iff1_d;
      iff2_q <= iff2_d;
    end
  end

  assign iff1 = iff1_q;
  assign iff2 = iff2_q;

  a_r2_di_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_end && di) |=> (!iff1_q && !iff2_q));
  a_r3_ei_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_end && ei && !di) |=> (iff1_q && iff2_q));
  a_r4_ack_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> (iff1_q && ins_end && irq_req));
  a_r4_no_ack_on_ei: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_end && ei) |-> !irq_ack);
  a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> (!iff1_q && !iff2_q));

endmodule

// File: rtl/intctl_halt.sv
module intctl_halt
  import intctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       halt,
  input  logic       im,
  input  logic [1:0] im_sel,
  input  logic       irq_ack,
  output logic       halted,
  output logic [1:0] int_mode
);

  logic   halted_q, halted_d;
  imode_e mode_q, mode_d;

  always_comb begin
    halted_d = halted_q;
    if (irq_ack)   halted_d = 1'b0;
    else if (halt) halted_d = 1'b1;
  end

  always_comb begin
    mode_d = mode_q;
    if (im && (im_sel != 2'd3)) mode_d = imode_e'(im_sel);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halted_q <= 1'b0;
      mode_q   <= IMODE0;
    end else begin
      halted_q <= halted_d;
      mode_q   <= mode_d;
    end
  end

  assign halted   = halted_q;
  assign int_mode = mode_q;

  a_r6_halt_enters: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !irq_ack) |=> halted_q);
  a_r7_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (halted_q && !irq_ack) |=> halted_q);
  a_r7_ack_wakes: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !halted_q);
  a_r8_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q != 2'd3);

endmodule

// File: rtl/intctl_cost.sv
module intctl_cost
  import intctl_pkg::*;
#(
  parameter int T_PER_M = 4,
  parameter int TW      = $clog2(2 * T_PER_M + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ins_end,
  input  ctl_op_t       op,
  output logic [TW-1:0] cost_t,
  output logic [1:0]    cost_m
);

  logic [TW-1:0] t_q, t_d;
  logic [1:0]    m_q, m_d;

  always_comb begin
    t_d = t_q;
    m_d = m_q;
    if (ins_end) begin
      if (op.im) begin
        t_d = TW'(2 * T_PER_M);
        m_d = 2'd2;
      end else if (op.nop || op.halt || op.di || op.ei) begin
        t_d = TW'(T_PER_M);
        m_d = 2'd1;
      end else begin
        t_d = '0;
        m_d = 2'd0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_q <= '0;
      m_q <= 2'd0;
    end else begin
      t_q <= t_d;
      m_q <= m_d;
    end
  end

  assign cost_t = t_q;
  assign cost_m = m_q;

  a_r9_im_cost: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_end && op.im) |=> (t_q == TW'(2 * T_PER_M) && m_q == 2'd2));
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ins_end |=> ($stable(t_q) && $stable(m_q)));

endmodule

// File: rtl/intctl_top.sv
module intctl_top
  import intctl_pkg::*;
#(
  parameter int T_PER_M = 4,
  parameter int EI_HOLD = 1,
  parameter int TW      = $clog2(2 * T_PER_M + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ins_end,
  input  logic          op_nop,
  input  logic          op_halt,
  input  logic          op_di,
  input  logic          op_ei,
  input  logic          op_im,
  input  logic [1:0]    im_sel,
  input  logic          irq_req,
  output logic          iff1,
  output logic          iff2,
  output logic [1:0]    int_mode,
  output logic          halted,
  output logic          dummy_fetch,
  output logic          irq_ack,
  output logic [TW-1:0] cost_t,
  output logic [1:0]    cost_m
);

  ctl_op_t op_q;

  // strobes only count at a boundary (R10)
  assign op_q = '{nop:  op_nop  & ins_end,
                  halt: op_halt & ins_end,
                  di:   op_di   & ins_end,
                  ei:   op_ei   & ins_end,
                  im:   op_im   & ins_end};

  intctl_enable #(.EI_HOLD(EI_HOLD)) u_enable (
    .clk     (clk),
    .rst_n   (rst_n),
    .ins_end (ins_end),
    .di      (op_q.di),
    .ei      (op_q.ei),
    .irq_req (irq_req),
    .iff1    (iff1),
    .iff2    (iff2),
    .irq_ack (irq_ack)
  );

  intctl_halt u_halt (
    .clk      (clk),
    .rst_n    (rst_n),
    .halt     (op_q.halt),
    .im       (op_q.im),
    .im_sel   (im_sel),
    .irq_ack  (irq_ack),
    .halted   (halted),
    .int_mode (int_mode)
  );

  intctl_cost #(.T_PER_M(T_PER_M), .TW(TW)) u_cost (
    .clk     (clk),
    .rst_n   (rst_n),
    .ins_end (ins_end),
    .op      (op_q),
    .cost_t  (cost_t),
    .cost_m  (cost_m)
  );

  assign dummy_fetch = halted;

  a_r6_fetch_tracks_halt: assert property (@(posedge clk) disable iff (!rst_n)
    dummy_fetch == halted);
  a_r10_no_boundary_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    !ins_end |=> ($stable(iff1) && $stable(iff2) && $stable(int_mode) && $stable(halted)));

endmodule

// File: tb/intctl_top_bench.sv
`timescale 1ns/1ps
module intctl_top_bench;

  localparam int OP_NONE = 0, OP_NOP = 1, OP_HALT = 2, OP_DI = 3,
                 OP_EI = 4, OP_IM = 5, OP_OTHER = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic ins_end, op_nop, op_halt, op_di, op_ei, op_im, irq_req;
  logic [1:0] im_sel;
  logic iff1, iff2, halted, dummy_fetch, irq_ack;
  logic [1:0] int_mode, cost_m;
  logic [3:0] cost_t;

  always #2.5 clk = ~clk;

  intctl_top u_intctl_top (
    .clk(clk), .rst_n(rst_n), .ins_end(ins_end),
    .op_nop(op_nop), .op_halt(op_halt), .op_di(op_di), .op_ei(op_ei),
    .op_im(op_im), .im_sel(im_sel), .irq_req(irq_req),
    .iff1(iff1), .iff2(iff2), .int_mode(int_mode), .halted(halted),
    .dummy_fetch(dummy_fetch), .irq_ack(irq_ack),
    .cost_t(cost_t), .cost_m(cost_m)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // reference state
  bit m_iff1, m_iff2, m_halt;
  int m_mode, m_t, m_m;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic bit ref_ack(input int op, input bit e, input bit irq);
    return e && irq && m_iff1 && (op != OP_EI) && (op != OP_DI);
  endfunction

  task automatic step(input int op, input bit e, input bit irq, input logic [1:0] sel);
    bit exp_ack;
    string tg_iff, tg_h;
    ins_end = e;
    op_nop  = (op == OP_NOP);
    op_halt = (op == OP_HALT);
    op_di   = (op == OP_DI);
    op_ei   = (op == OP_EI);
    op_im   = (op == OP_IM);
    im_sel  = sel;
    irq_req = irq;
    #1;
    exp_ack = ref_ack(op, e, irq);
    chk((e && op == OP_DI) ? "R2" : "R4", "irq_ack", int'(irq_ack), int'(exp_ack));
    // tags for the registered checks
    if (!e && op != OP_NONE && op != OP_OTHER) begin
      tg_iff = "R10"; tg_h = "R10";
    end else if (exp_ack) begin
      tg_iff = "R5"; tg_h = "R7";
    end else if (e && op == OP_DI) begin
      tg_iff = "R2"; tg_h = "R7";
    end else if (e && op == OP_EI) begin
      tg_iff = "R3"; tg_h = "R7";
    end else if (e && op == OP_HALT) begin
      tg_iff = "R11"; tg_h = "R6";
    end else begin
      tg_iff = "R11"; tg_h = "R7";
    end
    // model update at the edge
    if (e) begin
      if (exp_ack) begin
        m_iff1 = 1'b0; m_iff2 = 1'b0; m_halt = 1'b0;
      end else begin
        if (op == OP_DI) begin m_iff1 = 1'b0; m_iff2 = 1'b0; end
        if (op == OP_EI) begin m_iff1 = 1'b1; m_iff2 = 1'b1; end
        if (op == OP_HALT) m_halt = 1'b1;
      end
      if (op == OP_IM && sel != 2'd3) m_mode = int'(sel);
      if (op == OP_IM) begin m_t = 8; m_m = 2; end
      else if (op >= OP_NOP && op <= OP_EI) begin m_t = 4; m_m = 1; end
      else begin m_t = 0; m_m = 0; end
    end
    @(posedge clk);
    @(negedge clk);
    chk(tg_iff, "iff1", int'(iff1), int'(m_iff1));
    chk(tg_iff, "iff2", int'(iff2), int'(m_iff2));
    chk((e && op == OP_IM) ? "R8" : tg_iff, "int_mode", int'(int_mode), m_mode);
    chk(tg_h, "halted", int'(halted), int'(m_halt));
    chk("R6", "dummy_fetch", int'(dummy_fetch), int'(m_halt));
    chk(e ? "R9" : "R10", "cost_t", int'(cost_t), m_t);
    chk(e ? "R9" : "R10", "cost_m", int'(cost_m), m_m);
  endtask

  initial begin
    #(5ns * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d5e_ed01));
    rst_n = 1'b0;
    ins_end = 0; op_nop = 0; op_halt = 0; op_di = 0; op_ei = 0; op_im = 0;
    im_sel = 2'd0; irq_req = 1'b1;
    m_iff1 = 0; m_iff2 = 0; m_halt = 0; m_mode = 0; m_t = 0; m_m = 0;
    repeat (3) @(negedge clk);
    // R1: values held in reset
    chk("R1", "iff1", int'(iff1), 0);
    chk("R1", "iff2", int'(iff2), 0);
    chk("R1", "int_mode", int'(int_mode), 0);
    chk("R1", "halted", int'(halted), 0);
    chk("R1", "irq_ack", int'(irq_ack), 0);
    chk("R1", "cost_t", int'(cost_t), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "dummy_fetch", int'(dummy_fetch), 0);
    chk("R1", "cost_m", int'(cost_m), 0);

    // R4: enable blocks at its own boundary, next instruction lets it in
    step(OP_EI, 1, 1, 0);
    step(OP_NOP, 1, 1, 0);
    // R4: a chain of enables keeps blocking
    step(OP_EI, 1, 1, 0);
    step(OP_EI, 1, 1, 0);
    step(OP_EI, 1, 1, 0);
    step(OP_OTHER, 1, 1, 0);
    // R2: disable at its own boundary, request present
    step(OP_EI, 1, 0, 0);
    step(OP_NOP, 1, 0, 0);
    step(OP_DI, 1, 1, 0);
    // R6/R7: halt, dummy boundaries, wake by request
    step(OP_EI, 1, 0, 0);
    step(OP_NOP, 1, 0, 0);
    step(OP_HALT, 1, 0, 0);
    for (int i = 0; i < 4; i++) step(OP_NONE, 1, 0, 0);
    step(OP_NONE, 0, 1, 0);
    step(OP_NONE, 1, 1, 0);
    // R7: request at the halt's own boundary
    step(OP_EI, 1, 0, 0);
    step(OP_NOP, 1, 0, 0);
    step(OP_HALT, 1, 1, 0);
    // R8: modes, and the illegal operand
    step(OP_IM, 1, 0, 2'd2);
    step(OP_IM, 1, 0, 2'd3);
    step(OP_IM, 1, 0, 2'd1);
    // R10: strobes without a boundary
    step(OP_EI, 0, 0, 0);
    step(OP_IM, 0, 0, 2'd2);
    step(OP_HALT, 0, 0, 0);
    step(OP_NOP, 1, 0, 0);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      int op;
      bit e, irq;
      e   = ($urandom % 4) != 0;
      irq = ($urandom % 3) == 0;
      op  = $urandom % 7;
      if (m_halt) op = OP_NONE;
      step(op, e, irq, 2'($urandom % 4));
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule